// File: doc/BRIEF.md
# Atomic Multibyte Register Access Port

This block is a byte-wide host register port. It lets a host reach internal registers that are one to four bytes wide and still see a consistent value. A host reads a wide register one byte at a time, starting at its lowest address. That first read copies every upper byte of the live value into a shared read snapshot, and the following upper-byte reads return the copied bytes. The snapshot keeps the value coherent even while the register keeps changing.

Wide writes also start at the lowest byte and go up in order. The bytes gather in a shared write staging register, and the target register takes the whole new value in the cycle its top byte is written. If another access breaks into a sequence, or the bytes arrive out of order, the partial write is dropped.

A small demonstration map sits behind the port:
- a two-byte identity code;
- revision bytes;
- a status bit that follows a mode-select pin;
- a free-running 32-bit counter;
- writable registers of 16, 24 and 32 bits;
- one writable single-byte register.

Read data is combinational. It is valid in the same cycle as the read strobe and is 0x00 when no read is strobed. Multibyte registers sit at ascending addresses with the least significant byte at the lowest address. The read and write strobes are never asserted together.

Top module: `mbreg_port`

## Requirements
- R1: A write to the single-byte register at 0x1C takes effect at the next clock edge with no staging, and a read of 0x1C returns it.
- R2: A read of address 0x08 returns the live low byte of the counter and copies its upper three bytes. Later reads of 0x09, 0x0A and 0x0B, in that order with no other access between them, return the copied bytes however many idle cycles pass.
- R3: The counter at 0x08..0x0B (least significant byte at 0x08) is zero at reset and then increments by one on every clock edge.
- R4: A read of an upper byte that is not the next step of a valid read sequence returns the live byte. This covers an upper-byte read with no earlier low-byte read, and one made after any other access broke the sequence.
- R5: The writable registers occupy 0x10..0x11 (16 bits), 0x14..0x16 (24 bits) and 0x18..0x1B (32 bits), with the least significant byte at the lowest address. When written low byte first in ascending order, a register keeps its old value until its top byte is written and then holds all the written bytes, with any number of idle cycles between the writes.
- R6: A write sequence is discarded, leaving its target unchanged, in three cases: another access comes between its bytes, a byte is skipped, or an upper byte is written with no preceding low-byte write.
- R7: Address 0x00 reads 0x20, 0x01 reads 0x54, 0x02 reads the revision parameter (default 0x01) and 0x03 reads the sub-revision parameter (default 0x00).
- R8: Address 0x04 reads the mode-select pin in bit 0 and zero in bits 7:1.
- R9: Writes to read-only or unmapped addresses change nothing. Reads of unmapped addresses return 0x00, and the read data is 0x00 whenever no read is strobed.
- R10: Reset clears every writable register to zero and drops any pending read or write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register byte address |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid in the strobe cycle |
| mode_pin | input | 1 | Mode-select input shown at 0x04 bit 0 (1 = master) |

## Verification
The hardest case to reach is a snapshot that differs from the live value in its upper bytes. That needs enough cycles between the low-byte read and the upper-byte reads for the counter to carry into byte 1 and beyond. The bench therefore reads 0x08 and then idles for hundreds of cycles before reading the upper bytes. It compares the four bytes against its own cycle-count model, sampled at the moment of the low-byte read. The broken-sequence cases are driven the same way: an unrelated access is placed between the bytes, followed by a long gap, so that a live value and a held value cannot agree by chance.

// File: rtl/mbreg_port.sv
module mbreg_port #(
  parameter logic [7:0] REV_CODE = 8'h01,
  parameter logic [7:0] SUB_CODE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       mode_pin
);
  localparam logic [3:0] S_ID   = 4'd0;
  localparam logic [3:0] S_REV  = 4'd1;
  localparam logic [3:0] S_SUB  = 4'd2;
  localparam logic [3:0] S_STS  = 4'd3;
  localparam logic [3:0] S_CNT  = 4'd4;
  localparam logic [3:0] S_RA   = 4'd5;
  localparam logic [3:0] S_RB   = 4'd6;
  localparam logic [3:0] S_RC   = 4'd7;
  localparam logic [3:0] S_SCR  = 4'd8;
  localparam logic [3:0] S_NONE = 4'd15;

  logic [31:0] cnt_q;
  logic [15:0] ra_q;
  logic [23:0] rb_q;
  logic [31:0] rc_q;
  logic [7:0]  scr_q;

  logic        rd_act_q, wr_act_q;
  logic [3:0]  rd_sel_q, wr_sel_q;
  logic [1:0]  rd_nxt_q, wr_nxt_q;
  logic [23:0] rd_hold_q, wr_hold_q;

  logic [3:0]  sel;
  logic [1:0]  bsel, top;
  logic        rw;
  logic [31:0] live;

  always_comb begin
    sel  = S_NONE;
    bsel = 2'd0;
    top  = 2'd0;
    rw   = 1'b0;
    case (addr)
      8'h00, 8'h01:                 begin sel = S_ID;  bsel = addr[1:0]; top = 2'd1; end
      8'h02:                        sel = S_REV;
      8'h03:                        sel = S_SUB;
      8'h04:                        sel = S_STS;
      8'h08, 8'h09, 8'h0A, 8'h0B:   begin sel = S_CNT; bsel = addr[1:0]; top = 2'd3; end
      8'h10, 8'h11:                 begin sel = S_RA;  bsel = addr[1:0]; top = 2'd1; rw = 1'b1; end
      8'h14, 8'h15, 8'h16:          begin sel = S_RB;  bsel = addr[1:0]; top = 2'd2; rw = 1'b1; end
      8'h18, 8'h19, 8'h1A, 8'h1B:   begin sel = S_RC;  bsel = addr[1:0]; top = 2'd3; rw = 1'b1; end
      8'h1C:                        begin sel = S_SCR; rw = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (sel)
      S_ID:    live = 32'h0000_5420;
      S_REV:   live = {24'd0, REV_CODE};
      S_SUB:   live = {24'd0, SUB_CODE};
      S_STS:   live = {31'd0, mode_pin};
      S_CNT:   live = cnt_q;
      S_RA:    live = {16'd0, ra_q};
      S_RB:    live = {8'd0, rb_q};
      S_RC:    live = rc_q;
      S_SCR:   live = {24'd0, scr_q};
      default: live = 32'd0;
    endcase
  end

  wire       multi  = (top != 2'd0);
  wire [1:0] hidx   = bsel - 2'd1;
  wire [7:0] live_b = live[{bsel, 3'b000} +: 8];
  wire [7:0] hold_b = rd_hold_q[{hidx, 3'b000} +: 8];
  wire rd_hit = rd_en && rd_act_q && (rd_sel_q == sel) && (rd_nxt_q == bsel) && (bsel != 2'd0);
  wire wr_hit = wr_en && rw && wr_act_q && (wr_sel_q == sel) && (wr_nxt_q == bsel) && (bsel != 2'd0);

  assign rd_data = !rd_en ? 8'h00 : (rd_hit ? hold_b : live_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ra_q      <= '0;
      rb_q      <= '0;
      rc_q      <= '0;
      scr_q     <= '0;
      rd_act_q  <= 1'b0;
      wr_act_q  <= 1'b0;
      rd_sel_q  <= S_NONE;
      wr_sel_q  <= S_NONE;
      rd_nxt_q  <= '0;
      wr_nxt_q  <= '0;
      rd_hold_q <= '0;
      wr_hold_q <= '0;
    end else begin
      cnt_q <= cnt_q + 32'd1;
      if (rd_en || wr_en) begin
        rd_act_q <= 1'b0;
        wr_act_q <= 1'b0;
      end
      if (rd_en && multi) begin
        if (bsel == 2'd0) begin
          rd_act_q  <= 1'b1;
          rd_sel_q  <= sel;
          rd_nxt_q  <= 2'd1;
          rd_hold_q <= live[31:8];
        end else if (rd_hit && bsel != top) begin
          rd_act_q <= 1'b1;
          rd_nxt_q <= bsel + 2'd1;
        end
      end
      if (wr_en && rw) begin
        if (!multi) begin
          scr_q <= wr_data;
        end else if (bsel == 2'd0) begin
          wr_act_q       <= 1'b1;
          wr_sel_q       <= sel;
          wr_nxt_q       <= 2'd1;
          wr_hold_q[7:0] <= wr_data;
        end else if (wr_hit) begin
          if (bsel == top) begin
            case (sel)
              S_RA:    ra_q <= {wr_data, wr_hold_q[7:0]};
              S_RB:    rb_q <= {wr_data, wr_hold_q[15:0]};
              S_RC:    rc_q <= {wr_data, wr_hold_q};
              default: ;
            endcase
          end else begin
            wr_act_q                       <= 1'b1;
            wr_nxt_q                       <= bsel + 2'd1;
            wr_hold_q[{bsel, 3'b000} +: 8] <= wr_data;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mbreg_port_chk.sv
module mbreg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic        mode_pin,
  input logic [31:0] cnt_q,
  input logic [23:0] rb_q,
  input logic [31:0] rc_q,
  input logic [7:0]  scr_q
);
  logic up_q;
  always_ff @(posedge clk) up_q <= rst_n;

  a_r1_scratch_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == 8'h1C) |=> (scr_q == $past(wr_data)));

  a_r2_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 8'h08) |=>
      (!(rd_en && addr == 8'h09) || rd_data == $past(cnt_q[15:8])));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (cnt_q == $past(cnt_q) + 32'd1));

  a_r5_rc_commit_top: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h1B) |=> $stable(rc_q));

  a_r5_rb_commit_top: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h16) |=> $stable(rb_q));

  a_r8_status_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h04) |-> (rd_data == {7'd0, mode_pin}));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == 8'h00));
endmodule

bind mbreg_port mbreg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .mode_pin(mode_pin),
  .cnt_q(cnt_q), .rb_q(rb_q), .rc_q(rc_q), .scr_q(scr_q)
);

// File: tb/test_mbreg_port.sv
`timescale 1ns/1ps
module test_mbreg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       mode_pin = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] tb_cnt;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tb_cnt <= 32'd0;
    else        tb_cnt <= tb_cnt + 32'd1;
  end

  mbreg_port i_mbreg_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .mode_pin(mode_pin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic [31:0] c);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #5;
    d = rd_data; c = tb_cnt;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic rd32(input logic [7:0] base, output logic [31:0] v, output logic [31:0] c0, input int gap);
    logic [7:0] d; logic [31:0] c;
    rd(base, d, c0); v[7:0] = d;
    for (int i = 1; i < 4; i++) begin
      repeat (gap) @(posedge clk);
      rd(base + 8'(i), d, c); v[8*i +: 8] = d;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [31:0] c;
    wr(8'h10, 8'h12); wr(8'h11, 8'h34); wr(8'h1C, 8'h77);
    rd(8'h08, d, c);
    do_reset();
    #5; chk("R9 idle zero", {24'd0, rd_data}, 32'd0);
    rd(8'h10, d, c); chk("R10 ra lo", {24'd0, d}, 32'd0);
    rd(8'h11, d, c); chk("R10 ra hi", {24'd0, d}, 32'd0);
    rd(8'h1C, d, c); chk("R10 scratch", {24'd0, d}, 32'd0);
    repeat (300) @(posedge clk);
    rd(8'h09, d, c); chk("R10 no stale read seq", {24'd0, d}, {24'd0, c[15:8]});
  endtask

  task automatic t_ident();
    logic [7:0] d; logic [31:0] c;
    rd(8'h00, d, c); chk("R7 id lo", {24'd0, d}, 32'h20);
    rd(8'h01, d, c); chk("R7 id hi", {24'd0, d}, 32'h54);
    rd(8'h02, d, c); chk("R7 rev", {24'd0, d}, 32'h01);
    rd(8'h03, d, c); chk("R7 subrev", {24'd0, d}, 32'h00);
  endtask

  task automatic t_status();
    logic [7:0] d; logic [31:0] c;
    mode_pin = 1'b1;
    rd(8'h04, d, c); chk("R8 master", {24'd0, d}, 32'h01);
    mode_pin = 1'b0;
    rd(8'h04, d, c); chk("R8 slave", {24'd0, d}, 32'h00);
  endtask

  task automatic t_scratch();
    logic [7:0] d; logic [31:0] c;
    wr(8'h1C, 8'hA5);
    rd(8'h1C, d, c); chk("R1 scratch", {24'd0, d}, 32'hA5);
    wr(8'h1C, 8'h3C);
    rd(8'h1C, d, c); chk("R1 scratch rewrite", {24'd0, d}, 32'h3C);
  endtask

  task automatic t_snapshot();
    logic [31:0] v, c0;
    rd32(8'h08, v, c0, 700);
    chk("R2 coherent snapshot", v, c0);
    rd32(8'h08, v, c0, 0);
    chk("R3 counter value", v, c0);
  endtask

  task automatic t_abandon_read();
    logic [7:0] d; logic [31:0] c;
    rd(8'h08, d, c);
    wr(8'h1C, 8'h01);
    repeat (400) @(posedge clk);
    rd(8'h09, d, c); chk("R4 broken seq live", {24'd0, d}, {24'd0, c[15:8]});
    repeat (300) @(posedge clk);
    rd(8'h0A, d, c); chk("R4 no lsb live", {24'd0, d}, {24'd0, c[23:16]});
  endtask

  task automatic t_wide_write();
    logic [31:0] v, c0; logic [7:0] d; logic [31:0] c;
    wr(8'h18, 8'h11); repeat (50) @(posedge clk);
    wr(8'h19, 8'h22); repeat (20) @(posedge clk);
    wr(8'h1A, 8'h33); wr(8'h1B, 8'h44);
    rd32(8'h18, v, c0, 0); chk("R5 32-bit write", v, 32'h44332211);
    wr(8'h14, 8'hAB); wr(8'h15, 8'hCD); wr(8'h16, 8'hEF);
    rd(8'h14, d, c); v[7:0] = d; rd(8'h15, d, c); v[15:8] = d; rd(8'h16, d, c); v[23:16] = d;
    chk("R5 24-bit write", {8'd0, v[23:0]}, 32'h00EFCDAB);
    wr(8'h10, 8'h5A); wr(8'h11, 8'hC3);
    rd(8'h10, d, c); v[7:0] = d; rd(8'h11, d, c); v[15:8] = d;
    chk("R5 16-bit write", {16'd0, v[15:0]}, 32'h0000C35A);
    wr(8'h18, 8'h99); wr(8'h19, 8'h88); wr(8'h1A, 8'h77);
    rd32(8'h18, v, c0, 0); chk("R5 no commit before top", v, 32'h44332211);
  endtask

  task automatic t_write_interrupt();
    logic [31:0] v, c0; logic [7:0] d; logic [31:0] c;
    wr(8'h18, 8'hAA); wr(8'h19, 8'hBB);
    rd(8'h1C, d, c);
    wr(8'h1A, 8'hCC); wr(8'h1B, 8'hDD);
    rd32(8'h18, v, c0, 0); chk("R6 interrupted write", v, 32'h44332211);
    wr(8'h14, 8'h01); wr(8'h16, 8'h03);
    rd(8'h14, d, c); v[7:0] = d; rd(8'h15, d, c); v[15:8] = d; rd(8'h16, d, c); v[23:16] = d;
    chk("R6 skipped byte", {8'd0, v[23:0]}, 32'h00EFCDAB);
    wr(8'h11, 8'h66);
    rd(8'h10, d, c); v[7:0] = d; rd(8'h11, d, c); v[15:8] = d;
    chk("R6 top without lsb", {16'd0, v[15:0]}, 32'h0000C35A);
  endtask

  task automatic t_ro_ignore();
    logic [7:0] d; logic [31:0] c; logic [31:0] v, c0;
    wr(8'h00, 8'hFF); wr(8'h01, 8'hFF); wr(8'h04, 8'hFF);
    wr(8'h08, 8'h00); wr(8'h09, 8'h00); wr(8'h0A, 8'h00); wr(8'h0B, 8'h00);
    wr(8'h30, 8'h5A);
    rd(8'h00, d, c); chk("R9 id unchanged", {24'd0, d}, 32'h20);
    rd(8'h04, d, c); chk("R9 status unchanged", {24'd0, d}, 32'h00);
    rd32(8'h08, v, c0, 0); chk("R9 counter unchanged", v, c0);
    rd(8'h30, d, c); chk("R9 unmapped read", {24'd0, d}, 32'h00);
    rd(8'hFF, d, c); chk("R9 unmapped top", {24'd0, d}, 32'h00);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_ident();
    t_status();
    t_scratch();
    t_snapshot();
    t_abandon_read();
    t_wide_write();
    t_write_interrupt();
    t_ro_ignore();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule